// File: doc/BRIEF.md
# Banked Elementwise Vector Multiplier

This block forms the elementwise product of two integer vectors held in external memory. A one-cycle start pulse carries a requested element count. The block cuts that count down to its buffer capacity and then runs three phases strictly in turn. In the load phase it fetches element pairs into on-chip buffers. In the multiply phase it fills a result buffer with full-width products, several lanes at a time. In the store phase it streams the results back out. A one-cycle done pulse closes the run.

The on-chip buffers are split into one bank per lane, and element i lives in bank i mod LANES. A read port returns both operands of one index with fixed one-cycle latency. A write port accepts one result per cycle with no back-pressure. A parameter selects a pipelined multiply phase, which issues one lane group per cycle, or a sequential one, which waits for each group's products before it issues the next group.

Top module: `vec_mul_engine`

## Requirements
- R1: A requested length above DEPTH is treated as DEPTH. Exactly DEPTH reads and DEPTH writes happen, and no address reaches DEPTH.
- R2: The load phase asserts `rd_en` for consecutive cycles with `rd_addr` = 0, 1, ..., L-1, where L is the clamped length. Operand data is taken from `rd_a_data`/`rd_b_data` in the cycle after each `rd_en`.
- R3: Each result is the unsigned product of the two operands at the same index, 2*DATA_W bits wide, with no truncation (0xFFFF*0xFFFF = 0xFFFE0001 at DATA_W=16).
- R4: The store phase writes `wr_addr` = 0, 1, ..., L-1 on consecutive cycles. It begins only after every product has been written to the result buffer, and `rd_en` and `wr_en` are never high together.
- R5: A length of zero produces no read and no write, and `done` is high in the cycle right after the edge that samples start.
- R6: `done` is a single-cycle pulse, high in the cycle right after the last write.
- R7: A start pulse that arrives while a run is in progress is ignored. The run keeps its length and its results.
- R8: When L is not a multiple of LANES, the final group masks its surplus lanes, and elements 0..L-1 are still all correct.
- R9: Take the edge that samples start as edge 0, and let G = ceil(L/LANES). For L>0, `done` rises after edge 2L+G+2 when PIPE=1 and after edge 2L+2G+1 when PIPE=0. With PIPE=0 no two consecutive cycles issue a multiply group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, sampled only when idle |
| req_len | input | REQ_W | Requested element count |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Operand read request |
| rd_addr | output | $clog2(DEPTH) | Element index being read |
| rd_a_data | input | DATA_W | First operand, one cycle after rd_en |
| rd_b_data | input | DATA_W | Second operand, one cycle after rd_en |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | $clog2(DEPTH) | Element index being written |
| wr_data | output | 2*DATA_W | Full-width product |

## Verification
A corrupted phase or counter register shows up at the ports within one run. A missed or repeated index appears in the read or write address stream in the cycle it happens. A lane or bank fault surfaces as a wrong product at the store address of the affected element. A wrong group count or a mistimed phase change shifts the `done` cycle away from the closed-form latency of R9, so the bench compares every written element against a queued reference and also checks the exact completion cycle.

// File: rtl/vmul_pkg.sv
// Shared types for the banked vector multiplier.
package vmul_pkg;
    // Run phases, visited strictly in this order.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_MULT,
        PH_STORE,
        PH_DONE
    } vmul_phase_e;
endpackage

// File: rtl/vmul_lane.sv
// One multiply lane: private banks for both operands and for the result,
// plus a registered multiplier stage.
// Assumes: ld_we and mul_go never overlap; st_addr read is combinational.
module vmul_lane #(
    parameter int DATA_W = 16,
    parameter int BANK_D = 256,
    parameter int BA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_we,
    input  logic [BA_W-1:0]     ld_addr,
    input  logic [DATA_W-1:0]   ld_a,
    input  logic [DATA_W-1:0]   ld_b,
    input  logic                mul_go,
    input  logic [BA_W-1:0]     mul_addr,
    input  logic                mul_on,
    input  logic [BA_W-1:0]     st_addr,
    output logic [2*DATA_W-1:0] st_prod
);
    localparam int PW = 2 * DATA_W;

    logic [DATA_W-1:0] bank_a [BANK_D];
    logic [DATA_W-1:0] bank_b [BANK_D];
    logic [PW-1:0]     bank_p [BANK_D];
    logic [PW-1:0]     prod_q;
    logic [BA_W-1:0]   addr_q;
    logic              act_q;

    // Capture fetched operands into this lane's banks.
    always_ff @(posedge clk) begin
        if (ld_we) begin
            bank_a[ld_addr] <= ld_a;
            bank_b[ld_addr] <= ld_b;
        end
    end

    // Multiplier stage: full-width product and its target slot.
    always_ff @(posedge clk) begin
        prod_q <= PW'(bank_a[mul_addr]) * PW'(bank_b[mul_addr]);
        addr_q <= mul_addr;
    end

    // Write-enable for the result bank; masked lanes never write.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= mul_go && mul_on;
    end

    // Commit products into the result bank.
    always_ff @(posedge clk) begin
        if (act_q) bank_p[addr_q] <= prod_q;
    end

    // Result read for the store phase.
    always_comb st_prod = bank_p[st_addr];

    // R4
    load_mult_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> !mul_go);
endmodule

// File: rtl/vmul_seq.sv
// Phase sequencer: clamps the length, walks load, multiply and store
// indices and raises done. Assumes read data returns one cycle after rd_en.
module vmul_seq
    import vmul_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LANES = 4,
    parameter int PIPE  = 1,
    parameter int REQ_W = 16,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REQ_W-1:0] req_len,
    output logic [LEN_W-1:0] len_q,
    output logic             rd_en,
    output logic [LEN_W-1:0] rd_idx,
    output logic             ld_vld,
    output logic [LEN_W-1:0] ld_idx,
    output logic             mul_go,
    output logic [LEN_W-1:0] mul_grp,
    output logic             st_en,
    output logic [LEN_W-1:0] st_idx,
    output logic             done
);
    vmul_phase_e      phase;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] ld_idx_q;
    logic             ld_vld_q;
    logic             pend_q;
    logic [LEN_W-1:0] clamped;
    logic [LEN_W:0]   ngrp;

    // Length limit applied at start.
    always_comb clamped = (req_len > REQ_W'(DEPTH)) ? LEN_W'(DEPTH) : LEN_W'(req_len);

    // Number of lane groups for the current length.
    always_comb ngrp = ({1'b0, len_q} + (LEN_W+1)'(LANES - 1)) / (LEN_W+1)'(LANES);

    // Per-phase request strobes derived from the shared index counter.
    always_comb begin
        rd_en  = (phase == PH_LOAD) && (cnt_q < len_q);
        mul_go = (phase == PH_MULT) && ({1'b0, cnt_q} < ngrp) && ((PIPE != 0) || !pend_q);
        st_en  = (phase == PH_STORE) && (cnt_q < len_q);
        done   = (phase == PH_DONE);
    end

    assign rd_idx  = cnt_q;
    assign mul_grp = cnt_q;
    assign st_idx  = cnt_q;
    assign ld_vld  = ld_vld_q;
    assign ld_idx  = ld_idx_q;

    // Phase register, index counter and the returning-data trackers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt_q    <= '0;
            len_q    <= '0;
            ld_vld_q <= 1'b0;
            ld_idx_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            ld_vld_q <= rd_en;
            ld_idx_q <= cnt_q;
            pend_q   <= mul_go;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        len_q <= clamped;
                        cnt_q <= '0;
                        phase <= (clamped == '0) ? PH_DONE : PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    if (rd_en) cnt_q <= cnt_q + 1'b1;
                    if (ld_vld_q && ld_idx_q == len_q - LEN_W'(1)) begin
                        cnt_q <= '0;
                        phase <= PH_MULT;
                    end
                end
                PH_MULT: begin
                    if (mul_go) cnt_q <= cnt_q + 1'b1;
                    if (pend_q && {1'b0, cnt_q} == ngrp) begin
                        cnt_q <= '0;
                        phase <= PH_STORE;
                    end
                end
                PH_STORE: begin
                    if (st_en) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == len_q - LEN_W'(1)) phase <= PH_DONE;
                    end
                end
                PH_DONE:  phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // R1
    len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> (len_q <= LEN_W'(DEPTH)));
    // R5
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start && req_len == '0) |=> done);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && st_idx == len_q - LEN_W'(1)) |=> done);
    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && start) |=> $stable(len_q));
    // R4
    store_after_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> !pend_q);

    generate
        if (PIPE == 0) begin : g_seq_chk
            // R9
            no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mul_go |=> !mul_go);
        end
    endgenerate
endmodule

// File: rtl/vec_mul_engine.sv
// Top: buffered elementwise multiplier. Banks element i into lane i mod
// LANES. Assumes LANES is a power of two that divides DEPTH, REQ_W can
// hold DEPTH, read data arrives one cycle after rd_en, writes never stall.
module vec_mul_engine #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    parameter int LANES  = 4,
    parameter int PIPE   = 1,
    parameter int REQ_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [REQ_W-1:0]           req_len,
    output logic                       done,
    output logic                       rd_en,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    input  logic [DATA_W-1:0]          rd_a_data,
    input  logic [DATA_W-1:0]          rd_b_data,
    output logic                       wr_en,
    output logic [$clog2(DEPTH)-1:0]   wr_addr,
    output logic [2*DATA_W-1:0]        wr_data
);
    localparam int AW     = $clog2(DEPTH);
    localparam int LEN_W  = $clog2(DEPTH + 1);
    localparam int PW     = 2 * DATA_W;
    localparam int BANK_D = DEPTH / LANES;
    localparam int BA_W   = (BANK_D > 1) ? $clog2(BANK_D) : 1;
    localparam int SW     = (LANES > 1) ? $clog2(LANES) : 1;

    generate
        if ((LANES & (LANES - 1)) != 0 || (DEPTH % LANES) != 0) begin : g_bad_cfg
            $error("LANES must be a power of two dividing DEPTH");
        end
    endgenerate

    logic [LEN_W-1:0] len_q, rd_idx, ld_idx, mul_grp, st_idx;
    logic             ld_vld, mul_go, st_en;
    logic [PW-1:0]    lane_prod [LANES];
    logic [SW-1:0]    st_sel;
    logic [31:0]      grp_base, len32;

    vmul_seq #(
        .DEPTH(DEPTH), .LANES(LANES), .PIPE(PIPE), .REQ_W(REQ_W), .LEN_W(LEN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len),
        .len_q(len_q), .rd_en(rd_en), .rd_idx(rd_idx),
        .ld_vld(ld_vld), .ld_idx(ld_idx),
        .mul_go(mul_go), .mul_grp(mul_grp),
        .st_en(st_en), .st_idx(st_idx), .done(done)
    );

    // First element index of the group being issued, for tail masking.
    always_comb begin
        grp_base = 32'(mul_grp) * 32'(LANES);
        len32    = 32'(len_q);
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic ld_we_l, on_l;
            // Route a returning pair to its bank and mask surplus lanes.
            always_comb begin
                ld_we_l = ld_vld && ((ld_idx % LEN_W'(LANES)) == LEN_W'(l));
                on_l    = (grp_base + 32'(l)) < len32;
            end
            vmul_lane #(.DATA_W(DATA_W), .BANK_D(BANK_D), .BA_W(BA_W)) u_lane (
                .clk(clk), .rst_n(rst_n),
                .ld_we(ld_we_l), .ld_addr(BA_W'(ld_idx / LEN_W'(LANES))),
                .ld_a(rd_a_data), .ld_b(rd_b_data),
                .mul_go(mul_go), .mul_addr(BA_W'(mul_grp)), .mul_on(on_l),
                .st_addr(BA_W'(st_idx / LEN_W'(LANES))), .st_prod(lane_prod[l])
            );
        end
    endgenerate

    // Drive the memory ports from the sequencer indices.
    always_comb begin
        st_sel  = SW'(st_idx % LEN_W'(LANES));
        rd_addr = AW'(rd_idx);
        wr_en   = st_en;
        wr_addr = AW'(st_idx);
        wr_data = lane_prod[st_sel];
    end

    // R4
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
    // R2
    load_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != '0) |-> $past(rd_en));
endmodule

// File: tb/tb_vec_mul_engine.sv
module tb_vec_mul_engine;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1024;
    localparam int LANES  = 4;
    localparam int PIPE   = 1;
    localparam int REQ_W  = 16;
    localparam int AW     = $clog2(DEPTH);
    localparam int PW     = 2 * DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [REQ_W-1:0]  req_len = '0;
    logic              done, rd_en, wr_en;
    logic [AW-1:0]     rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_a_data = '0, rd_b_data = '0;
    logic [PW-1:0]     wr_data;

    int checks = 0, fails = 0;
    int seed = 0;
    int rd_exp = 0;
    bit reported = 0;
    logic [AW-1:0] q_addr [$];
    logic [PW-1:0] q_data [$];

    always #10 clk = ~clk;

    vec_mul_engine #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(LANES),
                     .PIPE(PIPE), .REQ_W(REQ_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len),
        .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    function automatic logic [DATA_W-1:0] op_a(int i, int s);
        return (i == 0) ? 16'hFFFF : DATA_W'(i * 911 + s * 7 + 3);
    endfunction
    function automatic logic [DATA_W-1:0] op_b(int i, int s);
        return (i == 0) ? 16'hFFFF : DATA_W'(i * 263 + s * 13 + 1);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    endtask

    // Memory model: operands for the address read in the previous cycle.
    always @(posedge clk) begin
        rd_a_data <= op_a(int'(rd_addr), seed);
        rd_b_data <= op_b(int'(rd_addr), seed);
    end

    // Monitor: read order (R2), exclusivity (R4), scoreboard of writes (R3, R4).
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) begin
                check(int'(rd_addr) == rd_exp, "R2 rd_addr", rd_addr, rd_exp);
                rd_exp++;
            end
            if (rd_en && wr_en) check(0, "R4 rd/wr overlap", 1, 0);
            if (wr_en) begin
                if (q_addr.size() == 0) begin
                    check(0, "R4 extra write", wr_addr, -1);
                end else begin
                    logic [AW-1:0] ea;
                    logic [PW-1:0] ed;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    check(wr_addr == ea, "R4 wr_addr", wr_addr, ea);
                    check(wr_data == ed, "R3 wr_data", wr_data, ed);
                end
            end
        end
    end

    // Driver: queue the reference results, pulse start, time the done pulse.
    task automatic run_case(int req, int s, bit busy_poke, string tag);
        int eff, grp, lat_exp, k;
        bit seen;
        eff  = (req > DEPTH) ? DEPTH : req;
        grp  = (eff + LANES - 1) / LANES;
        seed = s;
        rd_exp = 0;
        for (int i = 0; i < eff; i++) begin
            q_addr.push_back(AW'(i));
            q_data.push_back(PW'(op_a(i, s)) * PW'(op_b(i, s)));
        end
        if (eff == 0)       lat_exp = 0;
        else if (PIPE != 0) lat_exp = 2 * eff + grp + 2;
        else                lat_exp = 2 * eff + 2 * grp + 1;
        @(negedge clk);
        start = 1'b1;
        req_len = REQ_W'(req);
        @(negedge clk);
        start = 1'b0;
        k = 0;
        seen = 0;
        for (int c = 0; c < 10000; c++) begin
            if (done) begin seen = 1; break; end
            if (busy_poke && k == 3) begin start = 1'b1; req_len = REQ_W'(3); end
            else start = 1'b0;
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check(seen, {tag, " R6 done seen"}, seen, 1);
        check(k == lat_exp, {tag, " R9 done cycle"}, k, lat_exp);
        check(q_addr.size() == 0, {tag, " R1 all writes"}, q_addr.size(), 0);
        check(rd_exp == eff, {tag, " R1 read count"}, rd_exp, eff);
        @(negedge clk);
        check(!done, {tag, " R6 single pulse"}, done, 0);
        q_addr.delete();
        q_data.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !rd_en && !wr_en, "R6 reset quiet", {done, rd_en, wr_en}, 0);
        run_case(0, 1, 0, "R5 zero");
        run_case(1, 2, 0, "R3 single");
        run_case(7, 3, 0, "R8 tail");
        run_case(8, 4, 0, "R3 full groups");
        run_case(3, 5, 0, "R8 short");
        run_case(8, 6, 1, "R7 busy start");
        run_case(DEPTH, 7, 0, "R1 capacity");
        run_case(1500, 8, 0, "R1 over capacity");
        report();
    end

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        report();
    end
endmodule